// File: doc/BRIEF.md
# BCD Calendar Clock with Shadowed Register Bank

This block keeps wall-clock time and calendar date on a one-pulse-per-second tick. It holds seconds, minutes, 24-hour hours, day of week, day of month, month, year and century as packed BCD, with the tens digit in the upper nibble. Software reaches it through a byte-wide synchronous bus with an 11-bit address. Read data appears on `bus_rdata` one clock after the request.

The counters are not visible directly. Software sees a bank of copies, and every copy is reloaded in the same cycle whenever a tick arrives. A read-freeze bit in the control byte suspends that reload, so software can read a consistent snapshot while the real counters keep running. A write bit also suspends the reload and sends time writes to the copies only. Clearing the write bit moves every copy into the counters in one cycle. A stop bit in the seconds byte halts the counters. When a tick and a control write fall in the same cycle, the tick is handled against the old control value.

Top module: `bcd_timekeeper`

## Requirements
- R1: After a synchronous active-low reset, every field reads zero except day of week, date and month, which read 0x01. The control, stop and frequency-test bits are 0.
- R2: Byte map, relative to base 0x7F0: 0x0 flags, 0x1 century, 0x8 control, 0x9 seconds, 0xA minutes, 0xB hours, 0xC day of week, 0xD date, 0xE month, 0xF year. Read data is valid one clock after the request. Offsets 0x2–0x7 and any address outside the bank read 0x00.
- R3: On a tick, seconds 59 wraps to 00 and carries into minutes; minutes 59 wraps to 00 and carries into hours; hours 23 wraps to 00 and carries into the day.
- R4: A day carry steps day of week, with 07 wrapping to 01, and steps the date. Date wraps to 01 after the last day of the month (30 for months 04/06/09/11, 29 for month 02 in a year divisible by 4, 28 for other 02, otherwise 31) and carries into month. Month 12 wraps to 01 and carries into year.
- R5: Year 99 wraps to 00 and carries into century. Century 99 wraps to 00.
- R6: Bit 7 of the seconds byte is a stop bit. It can be written at any time and reads back. While it is 1, ticks do not advance the counters.
- R7: While control bit 6 (read freeze) is 1, ticks do not reload the copies, but the counters keep advancing. After the bit is cleared, the copies keep their old value until the next tick, which loads the current count.
- R8: When a tick and a control write land in the same cycle, the reload decision uses the control value from before the write.
- R9: While control bit 7 (write) is 1, writes to time bytes update the copies only. Clearing the bit loads every copy into the counters in one cycle. Time-byte writes while bit 7 is 0 have no effect on the time fields.
- R10: The control byte stores all 8 bits and reads them back: bit 7 write, bit 6 freeze, bit 5 calibration sign, bits 4:0 calibration magnitude. Bit 6 of the day byte is a frequency-test bit that is stored at any time and reads back. Flags bit 4 reflects `batt_low`, and all other flag bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| batt_low | input | 1 | Battery-low status, shown in the flags byte |
| bus_cs | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, one clock after the request |

## Verification
The bench uses the default parameters: an 11-bit address with the bank at 0x7F0. Every register is therefore reachable at its real address, and addresses outside the bank are also exercised. Preloading times through the write bit puts each carry boundary one tick away: leap and non-leap February, a 30-day month, and the end of a century year. The tests then check freezes, stops and same-cycle tick/control collisions against the second count they should produce.

// File: rtl/tk_pkg.sv
// Shared types and BCD helpers for the calendar clock.
// Assumes all stored values are valid packed BCD.
package tk_pkg;

    typedef struct packed {
        logic [7:0] cen;
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hr;
        logic [7:0] mnt;
        logic [7:0] sec;
    } tk_time_t;

    localparam tk_time_t TK_RESET = '{cen: 8'h00, yr: 8'h00, mon: 8'h01,
                                      mday: 8'h01, wday: 8'h01, hr: 8'h00,
                                      mnt: 8'h00, sec: 8'h00};

    // Byte offsets inside the bank; the decode depends on them.
    localparam logic [3:0] OFS_FLAG = 4'h0;
    localparam logic [3:0] OFS_CEN  = 4'h1;
    localparam logic [3:0] OFS_CTRL = 4'h8;
    localparam logic [3:0] OFS_SEC  = 4'h9;
    localparam logic [3:0] OFS_MNT  = 4'hA;
    localparam logic [3:0] OFS_HR   = 4'hB;
    localparam logic [3:0] OFS_WDAY = 4'hC;
    localparam logic [3:0] OFS_MDAY = 4'hD;
    localparam logic [3:0] OFS_MON  = 4'hE;
    localparam logic [3:0] OFS_YR   = 4'hF;

    // Add one to a two-digit packed BCD value.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
        else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last day of a month in BCD; leap years are those divisible by 4.
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        logic leap;
        leap = yr[4] ? (yr[3:0] == 4'd2 || yr[3:0] == 4'd6)
                     : (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8);
        case (mon)
            8'h02:                      month_last = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
            default:                    month_last = 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/tk_counters.sv
// Internal calendar counters. They advance on a tick unless stopped,
// and load a full time value in one cycle when asked.
// Assumes tick is a single-cycle pulse.
module tk_counters
    import tk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     stop,
    input  logic     load,
    input  tk_time_t load_val,
    output tk_time_t cnt,
    output tk_time_t cnt_next
);

    logic adv;
    assign adv = tick && !stop;

    // Compute the post-tick value with the full carry chain.
    always_comb begin
        cnt_next = cnt;
        if (adv) begin
            if (cnt.sec != 8'h59) cnt_next.sec = bcd_inc(cnt.sec);
            else begin
                cnt_next.sec = 8'h00;
                if (cnt.mnt != 8'h59) cnt_next.mnt = bcd_inc(cnt.mnt);
                else begin
                    cnt_next.mnt = 8'h00;
                    if (cnt.hr != 8'h23) cnt_next.hr = bcd_inc(cnt.hr);
                    else begin
                        cnt_next.hr   = 8'h00;
                        cnt_next.wday = (cnt.wday >= 8'h07) ? 8'h01 : cnt.wday + 8'h01;
                        if (cnt.mday < month_last(cnt.mon, cnt.yr)) cnt_next.mday = bcd_inc(cnt.mday);
                        else begin
                            cnt_next.mday = 8'h01;
                            if (cnt.mon < 8'h12) cnt_next.mon = bcd_inc(cnt.mon);
                            else begin
                                cnt_next.mon = 8'h01;
                                if (cnt.yr != 8'h99) cnt_next.yr = bcd_inc(cnt.yr);
                                else begin
                                    cnt_next.yr  = 8'h00;
                                    cnt_next.cen = (cnt.cen == 8'h99) ? 8'h00 : bcd_inc(cnt.cen);
                                end
                            end
                        end
                    end
                end
            end
        end
    end

    // Counter register: a load takes priority over advancing.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= TK_RESET;
        else if (load) cnt <= load_val;
        else           cnt <= cnt_next;
    end

    assert_stop_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load) |=> $stable(cnt));

    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !stop && !load && cnt.sec == 8'h59) |=> (cnt.sec == 8'h00));

endmodule

// File: rtl/tk_shadow.sv
// User-visible copy bank. All fields reload together on refresh;
// otherwise single fields take masked bus writes.
// Assumes refresh and wr_time never coincide (the top guarantees it).
module tk_shadow
    import tk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       refresh,
    input  tk_time_t   src,
    input  logic       wr_time,
    input  logic [3:0] wr_ofs,
    input  logic [7:0] wr_data,
    output tk_time_t   vis
);

    // Hold, reload from the counters, or take one masked field write.
    always_ff @(posedge clk) begin
        if (!rst_n)       vis <= TK_RESET;
        else if (refresh) vis <= src;
        else if (wr_time) begin
            case (wr_ofs)
                OFS_CEN:  vis.cen  <= wr_data;
                OFS_SEC:  vis.sec  <= {1'b0, wr_data[6:0]};
                OFS_MNT:  vis.mnt  <= {1'b0, wr_data[6:0]};
                OFS_HR:   vis.hr   <= {2'b0, wr_data[5:0]};
                OFS_WDAY: vis.wday <= {5'b0, wr_data[2:0]};
                OFS_MDAY: vis.mday <= {2'b0, wr_data[5:0]};
                OFS_MON:  vis.mon  <= {3'b0, wr_data[4:0]};
                OFS_YR:   vis.yr   <= wr_data;
                default:  ;
            endcase
        end
    end

    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh && !wr_time) |=> $stable(vis));

endmodule

// File: rtl/bcd_timekeeper.sv
// Calendar clock top: bus decode, control/stop/test bits, counters and
// visible copy bank. Reads are registered (one clock of latency).
// Assumes one bus access per cycle and a single-cycle tick pulse.
module bcd_timekeeper
    import tk_pkg::*;
#(
    parameter int              ADDR_W    = 11,
    parameter logic [ADDR_W-1:0] BANK_BASE = 11'h7F0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              batt_low,
    input  logic              bus_cs,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);

    localparam int PAGE_W = ADDR_W - 4;

    logic       hit, wr_en, rd_en, is_time;
    logic [3:0] ofs;
    logic [7:0] ctrl_q;
    logic       stop_q, ftest_q;
    logic       refresh, load, wr_time;
    tk_time_t   cnt, cnt_next, vis;

    assign ofs     = bus_addr[3:0];
    assign hit     = (bus_addr[ADDR_W-1:4] == BANK_BASE[ADDR_W-1:4]);
    assign wr_en   = bus_cs && bus_we && hit;
    assign rd_en   = bus_cs && !bus_we;
    assign is_time = (ofs == OFS_CEN) || (ofs >= OFS_SEC);
    // Tick first: the reload uses the control value registered before this cycle.
    assign refresh = tick_1hz && !ctrl_q[7] && !ctrl_q[6];
    assign load    = wr_en && (ofs == OFS_CTRL) && ctrl_q[7] && !bus_wdata[7];
    assign wr_time = wr_en && is_time && ctrl_q[7];

    // Control byte, stop bit and frequency-test bit registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= 8'h00;
            stop_q  <= 1'b0;
            ftest_q <= 1'b0;
        end else if (wr_en) begin
            if (ofs == OFS_CTRL) ctrl_q  <= bus_wdata;
            if (ofs == OFS_SEC)  stop_q  <= bus_wdata[7];
            if (ofs == OFS_WDAY) ftest_q <= bus_wdata[6];
        end
    end

    tk_counters u_counters (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1hz),
        .stop     (stop_q),
        .load     (load),
        .load_val (vis),
        .cnt      (cnt),
        .cnt_next (cnt_next)
    );

    tk_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .refresh (refresh),
        .src     (cnt_next),
        .wr_time (wr_time),
        .wr_ofs  (ofs),
        .wr_data (bus_wdata),
        .vis     (vis)
    );

    // Registered read mux; reserved and out-of-bank addresses return zero.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= 8'h00;
        else if (rd_en) begin
            if (!hit) bus_rdata <= 8'h00;
            else begin
                case (ofs)
                    OFS_FLAG: bus_rdata <= {3'b000, batt_low, 4'b0000};
                    OFS_CEN:  bus_rdata <= vis.cen;
                    OFS_CTRL: bus_rdata <= ctrl_q;
                    OFS_SEC:  bus_rdata <= {stop_q, vis.sec[6:0]};
                    OFS_MNT:  bus_rdata <= vis.mnt;
                    OFS_HR:   bus_rdata <= vis.hr;
                    OFS_WDAY: bus_rdata <= {1'b0, ftest_q, 3'b000, vis.wday[2:0]};
                    OFS_MDAY: bus_rdata <= vis.mday;
                    OFS_MON:  bus_rdata <= vis.mon;
                    OFS_YR:   bus_rdata <= vis.yr;
                    default:  bus_rdata <= 8'h00;
                endcase
            end
        end
    end

    assert_refresh_coherent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |=> (vis == cnt));

    assert_freeze_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[6] && !ctrl_q[7]) |=> $stable(vis));

    assert_load_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == vis));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (!hit || (ofs >= 4'h2 && ofs <= 4'h7))) |=> (bus_rdata == 8'h00));

    assert_page_width_R2: assert final (PAGE_W > 0);

endmodule

// File: tb/bcd_timekeeper_tb_top.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor compares them.
module bcd_timekeeper_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        batt_low = 1'b0;
    logic        bus_cs = 1'b0;
    logic        bus_we = 1'b0;
    logic [10:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    finished = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [10:0] adr_q[$];

    always #10 clk = ~clk;

    bcd_timekeeper dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .batt_low  (batt_low),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // Monitor: a read seen at an edge has its data checked 2 ns later.
    always @(posedge clk) begin
        if (bus_cs && !bus_we && rst_n) begin
            #2;
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                logic [10:0] a;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = adr_q.pop_front();
                n_checks++;
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, a, bus_rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [10:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(t); adr_q.push_back(a);
        @(negedge clk);
        bus_cs = 1'b0;
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0;
    endtask

    task automatic tk();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic wr_tick(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_1hz = 1'b1;
        @(negedge clk);
        bus_cs = 1'b0; bus_we = 1'b0; tick_1hz = 1'b0;
    endtask

    // Preload a full time through the write bit (R9).
    task automatic set_time(input logic [7:0] s, mi, h, wd, md, mo, y, c);
        wr(11'h7F8, 8'h80);
        wr(11'h7F9, s);  wr(11'h7FA, mi); wr(11'h7FB, h);  wr(11'h7FC, wd);
        wr(11'h7FD, md); wr(11'h7FE, mo); wr(11'h7FF, y);  wr(11'h7F1, c);
        wr(11'h7F8, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R2 map
        rd(11'h7F9, 8'h00, "R1 sec");  rd(11'h7FA, 8'h00, "R1 min");
        rd(11'h7FB, 8'h00, "R1 hour"); rd(11'h7FC, 8'h01, "R1 wday");
        rd(11'h7FD, 8'h01, "R1 date"); rd(11'h7FE, 8'h01, "R1 month");
        rd(11'h7FF, 8'h00, "R1 year"); rd(11'h7F1, 8'h00, "R1 cent");
        rd(11'h7F8, 8'h00, "R1 ctrl"); rd(11'h7F0, 8'h00, "R1 flags");

        // R10 battery flag
        batt_low = 1'b1;
        rd(11'h7F0, 8'h10, "R10 flag");
        batt_low = 1'b0;

        // R9 load, R3 carries, R4 leap February
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h24, 8'h20);
        rd(11'h7F9, 8'h58, "R9 loaded sec");
        tk(); rd(11'h7F9, 8'h59, "R3 sec step");
        tk();
        rd(11'h7F9, 8'h00, "R3 sec wrap"); rd(11'h7FA, 8'h00, "R3 min wrap");
        rd(11'h7FB, 8'h00, "R3 hour wrap"); rd(11'h7FC, 8'h01, "R4 wday wrap");
        rd(11'h7FD, 8'h29, "R4 leap feb"); rd(11'h7FE, 8'h02, "R4 leap month");

        // R4 non-leap February
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23, 8'h20);
        tk();
        rd(11'h7FD, 8'h01, "R4 feb28 date"); rd(11'h7FE, 8'h03, "R4 feb28 month");
        rd(11'h7FC, 8'h04, "R4 wday step");

        // R5 century carry
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h19);
        tk();
        rd(11'h7FD, 8'h01, "R5 date"); rd(11'h7FE, 8'h01, "R5 month");
        rd(11'h7FF, 8'h00, "R5 year"); rd(11'h7F1, 8'h20, "R5 century");

        // R4 30-day month
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h23, 8'h20);
        tk();
        rd(11'h7FD, 8'h01, "R4 apr30 date"); rd(11'h7FE, 8'h05, "R4 apr30 month");

        // R9 time writes ignored with write bit clear
        wr(11'h7FA, 8'h33);
        rd(11'h7FA, 8'h00, "R9 ignored write");
        tk();
        rd(11'h7FA, 8'h00, "R9 ignored after tick"); rd(11'h7F9, 8'h01, "R9 sec");

        // R6 stop bit
        wr(11'h7F9, 8'h80);
        rd(11'h7F9, 8'h81, "R6 stop readback");
        tk(); tk();
        rd(11'h7F9, 8'h81, "R6 stopped");
        wr(11'h7F9, 8'h00);
        tk();
        rd(11'h7F9, 8'h02, "R6 resumed");

        // R7 freeze
        wr(11'h7F8, 8'h40);
        tk(); tk(); tk();
        rd(11'h7F9, 8'h02, "R7 frozen");
        wr(11'h7F8, 8'h00);
        rd(11'h7F9, 8'h02, "R7 wait for tick");
        tk();
        rd(11'h7F9, 8'h06, "R7 counters ran");

        // R8 tick with control write in same cycle
        wr_tick(11'h7F8, 8'h40);
        rd(11'h7F9, 8'h07, "R8 tick before freeze");
        tk();
        rd(11'h7F9, 8'h07, "R8 frozen after");
        wr_tick(11'h7F8, 8'h00);
        rd(11'h7F9, 8'h07, "R8 tick before unfreeze");
        tk();
        rd(11'h7F9, 8'h10, "R8 refresh resumes");

        // R10 control byte and frequency-test bit
        wr(11'h7F8, 8'h3F);
        rd(11'h7F8, 8'h3F, "R10 ctrl readback");
        wr(11'h7FC, 8'h40);
        rd(11'h7FC, 8'h43, "R10 ftest bit");
        wr(11'h7F8, 8'h00);

        // R2 reserved and out-of-bank
        rd(11'h7F4, 8'h00, "R2 reserved");
        rd(11'h7F7, 8'h00, "R2 reserved top");
        rd(11'h100, 8'h00, "R2 outside bank");

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule